// File: doc/BRIEF.md
# Per-Port Clock Quality Message Handler

This block sits beside each Ethernet port of a frequency-synchronised node and handles the one-byte clock-quality status carried between neighbours. On the receive side it takes a decoded status byte with a one-cycle valid strobe. It splits the byte into a 4-bit quality code and a 4-bit source identifier and holds them as the port's current view of its peer. A silence watchdog counts one-second ticks. When five ticks pass with no message, the reported quality drops to the "do not use" code, so the reference selector stops trusting that line.

On the transmit side the block emits one status byte for every one-second tick. The byte normally carries the node's system quality. When this port's line clock is the selected reference, the block sends the "do not use" code back toward the peer instead, which keeps the peer from locking onto a signal that it originally supplied. In extended mode the upper nibble of each byte holds a source identifier: the block transmits its local identifier there and accepts the peer's identifier from there. In plain mode that nibble is sent as zero and ignored on receipt.

Top module: `ssm_port_handler`

## Requirements
- R1: Straight after reset, `rxQl` equals the do-not-use code (4'hF by default), `rxId` is 0, `timedOut` is 0 and `txValid` is 0.
- R2: In the cycle after `rxValid` is sampled high, `rxQl` equals bits [3:0] of the `rxByte` that was sampled.
- R3: On a valid receive with `extMode`=1, `rxId` takes bits [7:4] of `rxByte`. With `extMode`=0, `rxId` becomes 0.
- R4: After five `secTick` pulses are sampled without an intervening valid receive, `timedOut` is 1 and `rxQl` reads the do-not-use code from the cycle after the fifth tick. After only four ticks, `timedOut` is still 0.
- R5: A valid receive restarts the silence count. When a receive and a tick are sampled in the same cycle, the receive wins and the count restarts from zero.
- R6: A valid receive while `timedOut` is 1 clears `timedOut` and shows the new quality code on `rxQl` in the very next cycle.
- R7: Each sampled `secTick` produces `txValid` high for exactly the following cycle. `txValid` is never high in any other cycle.
- R8: Bits [3:0] of `txByte` carry `sysQl` when `selected` is 0, and carry the do-not-use code when `selected` is 1. Both inputs are sampled with the tick.
- R9: Bits [7:4] of `txByte` carry `localId` when `extMode` is 1 and 0 when `extMode` is 0, sampled with the tick.
- R10: While `rxValid` is low, `rxByte` has no effect: `rxQl` and `rxId` stay unchanged in every cycle that has neither a receive nor a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse once per second |
| rxValid | input | 1 | Strobe marking a decoded received status byte |
| rxByte | input | 8 | Received status byte: quality in [3:0], source ID in [7:4] |
| extMode | input | 1 | 1 selects extended mode, where the upper nibble carries the ID |
| sysQl | input | 4 | Quality code of the node's system clock |
| localId | input | 4 | Source identifier this node sends in extended mode |
| selected | input | 1 | 1 when this port's line clock is the selected reference |
| rxQl | output | 4 | Current peer quality code, forced to do-not-use on timeout |
| rxId | output | 4 | Last received source identifier |
| timedOut | output | 1 | Peer has been silent for five ticks |
| txValid | output | 1 | One-cycle strobe marking a status byte to transmit |
| txByte | output | 8 | Status byte to transmit |

## Verification
Every result of this block arrives exactly one clock after the edge that samples its cause. `rxQl` and `rxId` update one cycle after a receive strobe. `timedOut` rises one cycle after the fifth silent tick. `txValid` and `txByte` appear in the cycle after each tick. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so every check lands in the single cycle where its result becomes due. A scoreboard queues the expected transmit byte at each tick. A falling-edge monitor pops one entry for every cycle in which `txValid` is high, and it also reports any strobe that arrives when no entry is waiting.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic captureRx;  // latch the received byte
    logic emitTx;     // build and strobe a transmit byte
  } ssmStrobe_t;

  localparam logic [3:0] DNU_DEFAULT = 4'hF;
endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int TIMEOUT_SEC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       rxValid,
  output ssmStrobe_t strobes,
  output logic       timedOut
);
  localparam int CNT_W = $clog2(TIMEOUT_SEC + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_SEC);

  logic [CNT_W-1:0] silenceCnt;

  // Count silent seconds, saturating at the limit; a received message wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      silenceCnt <= '0;
    end else if (rxValid) begin
      silenceCnt <= '0;
    end else if (secTick && (silenceCnt != CNT_LIMIT)) begin
      silenceCnt <= silenceCnt + 1'b1;
    end
  end

  assign timedOut          = (silenceCnt == CNT_LIMIT);
  assign strobes.captureRx = rxValid;
  assign strobes.emitTx    = secTick;
endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath
  import ssm_pkg::*;
#(
  parameter int         QL_W     = 4,
  parameter int         ID_W     = 4,
  parameter logic [3:0] DNU_CODE = DNU_DEFAULT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ssmStrobe_t             strobes,
  input  logic                   timedOut,
  input  logic [QL_W+ID_W-1:0]   rxByte,
  input  logic                   extMode,
  input  logic [QL_W-1:0]        sysQl,
  input  logic [ID_W-1:0]        localId,
  input  logic                   selected,
  output logic [QL_W-1:0]        rxQl,
  output logic [ID_W-1:0]        rxId,
  output logic                   txValid,
  output logic [QL_W+ID_W-1:0]   txByte
);
  localparam int BYTE_W = QL_W + ID_W;
  localparam logic [QL_W-1:0] DNU_Q = QL_W'(DNU_CODE);

  logic [QL_W-1:0] qlReg;
  logic [ID_W-1:0] idReg;
  logic [QL_W-1:0] txQl;
  logic [ID_W-1:0] txId;

  // Receive side: keep the last message fields.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qlReg <= DNU_Q;
      idReg <= '0;
    end else if (strobes.captureRx) begin
      qlReg <= rxByte[QL_W-1:0];
      idReg <= extMode ? rxByte[BYTE_W-1:QL_W] : '0;
    end
  end

  assign rxQl = timedOut ? DNU_Q : qlReg;
  assign rxId = idReg;

  // Transmit side: return-path do-not-use when this line is the reference.
  assign txQl = selected ? DNU_Q : sysQl;
  assign txId = extMode ? localId : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= strobes.emitTx;
      if (strobes.emitTx) txByte <= {txId, txQl};
    end
  end
endmodule

// File: rtl/ssm_port_handler.sv
module ssm_port_handler
  import ssm_pkg::*;
#(
  parameter int         TIMEOUT_SEC = 5,
  parameter logic [3:0] DNU_CODE    = DNU_DEFAULT
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       extMode,
  input  logic [3:0] sysQl,
  input  logic [3:0] localId,
  input  logic       selected,
  output logic [3:0] rxQl,
  output logic [3:0] rxId,
  output logic       timedOut,
  output logic       txValid,
  output logic [7:0] txByte
);
  ssmStrobe_t strobes;

  ssm_ctrl #(.TIMEOUT_SEC(TIMEOUT_SEC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .rxValid  (rxValid),
    .strobes  (strobes),
    .timedOut (timedOut)
  );

  ssm_datapath #(.QL_W(4), .ID_W(4), .DNU_CODE(DNU_CODE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .timedOut (timedOut),
    .rxByte   (rxByte),
    .extMode  (extMode),
    .sysQl    (sysQl),
    .localId  (localId),
    .selected (selected),
    .rxQl     (rxQl),
    .rxId     (rxId),
    .txValid  (txValid),
    .txByte   (txByte)
  );
endmodule

// File: rtl/ssm_port_checker.sv
module ssm_port_checker #(
  parameter logic [3:0] DNU_CODE = 4'hF
) (
  input logic       clk,
  input logic       rstN,
  input logic       secTick,
  input logic       rxValid,
  input logic [7:0] rxByte,
  input logic       selected,
  input logic [3:0] rxQl,
  input logic [3:0] rxId,
  input logic       timedOut,
  input logic       txValid,
  input logic [7:0] txByte
);
  a_r2_capture_quality: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (rxQl == $past(rxByte[3:0])));

  a_r6_receive_clears_timeout: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !timedOut);

  a_r7_tick_gives_strobe: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> txValid);

  a_r7_no_strobe_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> !txValid);

  a_r8_return_path_dnu: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && selected) |=> (txByte[3:0] == DNU_CODE));

  a_r10_idle_holds_fields: assert property (@(posedge clk) disable iff (!rstN)
    (!rxValid && !secTick) |=> ($stable(rxQl) && $stable(rxId)));
endmodule

bind ssm_port_handler ssm_port_checker #(.DNU_CODE(DNU_CODE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .secTick  (secTick),
  .rxValid  (rxValid),
  .rxByte   (rxByte),
  .selected (selected),
  .rxQl     (rxQl),
  .rxId     (rxId),
  .timedOut (timedOut),
  .txValid  (txValid),
  .txByte   (txByte)
);

// File: tb/ssm_port_handler_bench.sv
module ssm_port_handler_bench;
  localparam logic [3:0] DNU = 4'hF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       extMode = 1'b0;
  logic [3:0] sysQl = 4'h2;
  logic [3:0] localId = 4'h0;
  logic       selected = 1'b0;
  logic [3:0] rxQl;
  logic [3:0] rxId;
  logic       timedOut;
  logic       txValid;
  logic [7:0] txByte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] txExpect[$];

  always #4 clk = ~clk;

  ssm_port_handler u_ssm_port_handler (
    .clk(clk), .rstN(rstN), .secTick(secTick), .rxValid(rxValid),
    .rxByte(rxByte), .extMode(extMode), .sysQl(sysQl), .localId(localId),
    .selected(selected), .rxQl(rxQl), .rxId(rxId), .timedOut(timedOut),
    .txValid(txValid), .txByte(txByte)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, starting and ending on a falling edge.
  task automatic step(input bit tick, input bit rv, input logic [7:0] b);
    secTick = tick;
    rxValid = rv;
    rxByte  = b;
    if (tick) txExpect.push_back({extMode ? localId : 4'h0, selected ? DNU : sysQl});
    @(negedge clk);
    secTick = 1'b0;
    rxValid = 1'b0;
    rxByte  = 8'hC3;  // junk on the idle bus
  endtask

  // Monitor: R7, R8, R9 scoreboard for transmitted bytes.
  always @(negedge clk) begin
    if (rstN && txValid) begin
      if (txExpect.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R7 actual=txValid expected=no strobe");
      end else begin
        chk("R8/R9 txByte", txByte, txExpect.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rxQl", {4'h0, rxQl}, {4'h0, DNU});
    chk("R1 rxId", {4'h0, rxId}, 8'h0);
    chk("R1 timedOut", {7'h0, timedOut}, 8'h0);
    chk("R1 txValid", {7'h0, txValid}, 8'h0);

    extMode = 1'b1;
    step(0, 1, 8'h3A);
    chk("R2 rxQl", {4'h0, rxQl}, 8'h0A);
    chk("R3 rxId ext", {4'h0, rxId}, 8'h03);
    extMode = 1'b0;
    step(0, 1, 8'h52);
    chk("R2 rxQl", {4'h0, rxQl}, 8'h02);
    chk("R3 rxId plain", {4'h0, rxId}, 8'h00);

    // R10: byte present without strobe
    rxByte = 8'h77;
    @(negedge clk);
    @(negedge clk);
    chk("R10 rxQl held", {4'h0, rxQl}, 8'h02);
    chk("R10 rxId held", {4'h0, rxId}, 8'h00);

    // Ticks with varied transmit settings (R7, R8, R9)
    sysQl = 4'h4; selected = 1'b0; extMode = 1'b0; localId = 4'h9;
    step(1, 0, 8'h00);
    chk("R7 strobe after tick", {7'h0, txValid}, 8'h1);
    @(negedge clk);
    chk("R7 single-cycle strobe", {7'h0, txValid}, 8'h0);
    selected = 1'b1;
    step(1, 0, 8'h00);
    extMode = 1'b1; selected = 1'b0; sysQl = 4'hB;
    step(1, 0, 8'h00);
    selected = 1'b1; localId = 4'h6;
    step(1, 0, 8'h00);
    chk("R4 four ticks no timeout", {7'h0, timedOut}, 8'h0);
    chk("R4 quality kept", {4'h0, rxQl}, 8'h02);
    step(1, 0, 8'h00);
    chk("R4 timeout after five", {7'h0, timedOut}, 8'h1);
    chk("R4 quality forced dnu", {4'h0, rxQl}, {4'h0, DNU});

    // R6: immediate recovery
    extMode = 1'b1;
    step(0, 1, 8'h14);
    chk("R6 timeout cleared", {7'h0, timedOut}, 8'h0);
    chk("R6 quality restored", {4'h0, rxQl}, 8'h04);
    chk("R3 rxId ext", {4'h0, rxId}, 8'h01);

    // R5: receive restarts the count
    selected = 1'b0; sysQl = 4'h1; extMode = 1'b0;
    for (int i = 0; i < 4; i++) step(1, 0, 8'h00);
    step(0, 1, 8'h05);
    for (int i = 0; i < 4; i++) step(1, 0, 8'h00);
    chk("R5 restart by receive", {7'h0, timedOut}, 8'h0);
    step(1, 1, 8'h06);
    for (int i = 0; i < 4; i++) step(1, 0, 8'h00);
    chk("R5 receive wins over tick", {7'h0, timedOut}, 8'h0);
    chk("R2 rxQl", {4'h0, rxQl}, 8'h06);
    step(1, 0, 8'h00);
    chk("R5 timeout after five more", {7'h0, timedOut}, 8'h1);

    repeat (3) @(negedge clk);
    chk("R7 all bytes seen", 8'(txExpect.size()), 8'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule